// File: doc/BRIEF.md
# Transaction Conflict Resolution Unit

This unit decides what happens when a transaction asks for a cache line that another transaction has already placed in its footprint. The transaction that already holds the line is the owner. The transaction asking for it is the requester. The conflict is treated as asymmetric: the owner already holds the data, so the usual outcome is that the requester waits. The owner is aborted only when the requester wins on priority, or when the owner has parked itself in a retry wait. A requester that has stalled too long is handed to software through a wait exception, which names the winning owner so that software can sleep the thread until that owner finishes.

Each cycle the requester presents its access kind, the owner's recorded access kind, both priorities, both transaction numbers and the owner's status flags. The unit registers one verdict per request cycle. The verdict codes are: 0 none, 1 stall, 2 abort owner, 3 wait exception. The unit also raises two other events. A retry wake-up is raised after it aborts an owner that was waiting in retry. A completion exception is raised when an owner that carries the except flag commits or aborts.

Top module: `txn_conflict_unit`

## Requirements
- R1: A read by the requester against a read by the owner gives verdict 0 (none) one cycle after the request. A `*_is_write` input is 1 for a write and 0 for a read.
- R2: When either side writes and the requester wins, the registered verdict is 2 (abort owner).
- R3: When `same_thread` and `own_paused` are both 1, the verdict is 0, whatever the access kinds, priorities and flags are.
- R4: The requester wins when its priority is strictly higher. When the priorities are equal, it wins when its transaction number is strictly lower. In every other case the owner wins.
- R5: An owner with `own_retry` set loses every real conflict, whatever the priorities are.
- R6: While the owner keeps winning, the verdict is 1 (stall) for the first STALL_LIMIT-1 consecutive cycles. On cycle STALL_LIMIT the verdict is 3, `wait_exc` pulses, and `wait_owner_id` equals `own_id`.
- R7: If `own_done` is 1 on the cycle the stall limit is reached, there is no wait exception: the verdict stays 1 and the count starts again.
- R8: When a retry-flagged owner is aborted, `wake_exc` pulses one cycle after the abort verdict, with `wake_id` equal to that owner's `own_id`.
- R9: `fin_valid` with `fin_except` set raises `cmpl_exc` with `cmpl_id` = `fin_id` on the next cycle. Without `fin_except` there is no pulse.
- R10: While reset is held, every output is 0.
- R11: Any cycle that is not an owner-wins conflict clears the stall count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_write | input | 1 | Requester access is a write |
| own_is_write | input | 1 | Owner recorded a write |
| req_prio | input | PRIO_W | Requester priority |
| own_prio | input | PRIO_W | Owner priority |
| req_txn | input | TXN_W | Requester transaction number |
| own_txn | input | TXN_W | Owner transaction number |
| same_thread | input | 1 | Owner belongs to the requester's thread |
| own_paused | input | 1 | Owner transaction is paused |
| own_retry | input | 1 | Owner is waiting in retry |
| own_done | input | 1 | Owner is committing or aborting |
| own_id | input | ID_W | Owner state pointer |
| fin_valid | input | 1 | An owner commits or aborts this cycle |
| fin_except | input | 1 | That owner carries the except flag |
| fin_id | input | ID_W | That owner's state pointer |
| res_valid | output | 1 | Verdict valid |
| res_code | output | 2 | Verdict code |
| wait_exc | output | 1 | Wait exception pulse |
| wait_owner_id | output | ID_W | Winning owner for the wait exception |
| wake_exc | output | 1 | Retry wake-up pulse |
| wake_id | output | ID_W | Aborted retry owner |
| cmpl_exc | output | 1 | Completion exception pulse |
| cmpl_id | output | ID_W | Completing owner |

## Verification
The bench sweeps every combination of access kinds, priorities, transaction numbers and the paused, retry and same-thread flags. This targets three kinds of error. A tie-break that lets equal transaction numbers favour the requester would abort owners that should win. A design that ignores the paused self-owner would stall a thread against itself. A design that weighs retry below priority would leave a retrying owner blocking others. Held stall runs check the exact cycle of the wait exception, and that the exception is withheld when the owner is finishing. A timer that misses a clear after an interruption, or that counts one cycle too many or too few, fires early or late. Completion and wake-up pulses are checked for their one-cycle delay and for the identifier they carry.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {
    CR_NONE        = 2'd0,
    CR_STALL       = 2'd1,
    CR_ABORT_OWNER = 2'd2,
    CR_WAIT_EXC    = 2'd3
  } cr_verdict_t;
endpackage

// File: rtl/cr_classify.sv
module cr_classify #(
  parameter int PRIO_W = 4,
  parameter int TXN_W  = 6
) (
  input  logic              req_is_write,
  input  logic              own_is_write,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] own_prio,
  input  logic [TXN_W-1:0]  req_txn,
  input  logic [TXN_W-1:0]  own_txn,
  input  logic              same_thread,
  input  logic              own_paused,
  input  logic              own_retry,
  output logic              hit,
  output logic              req_wins
);
  // any write on either side makes the access pair incompatible
  function automatic logic touch_conflict(input logic rw, input logic ow);
    return rw | ow;
  endfunction

  // strict priority first, lower transaction number breaks ties
  function automatic logic prio_beats(input logic [PRIO_W-1:0] rp, input logic [PRIO_W-1:0] op,
                                      input logic [TXN_W-1:0] rt, input logic [TXN_W-1:0] ot);
    if (rp != op) return rp > op;
    return rt < ot;
  endfunction

  logic self_paused;
  assign self_paused = same_thread & own_paused;
  assign hit         = touch_conflict(req_is_write, own_is_write) & ~self_paused;
  assign req_wins    = own_retry | prio_beats(req_prio, own_prio, req_txn, own_txn);
endmodule

// File: rtl/cr_stall_timer.sv
module cr_stall_timer #(
  parameter int STALL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owner_wins,
  input  logic own_done,
  output logic timeout,
  output logic wait_fire
);
  localparam int CW = $clog2(STALL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(STALL_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign timeout   = owner_wins & (cnt == LAST);
  assign wait_fire = timeout & ~own_done;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (!owner_wins || timeout) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cr_events.sv
module cr_events #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort_retry,
  input  logic [ID_W-1:0] own_id,
  input  logic            fin_valid,
  input  logic            fin_except,
  input  logic [ID_W-1:0] fin_id,
  output logic            wake_exc,
  output logic [ID_W-1:0] wake_id,
  output logic            cmpl_exc,
  output logic [ID_W-1:0] cmpl_id
);
  logic            pend;
  logic [ID_W-1:0] pend_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_id  <= '0;
      wake_exc <= 1'b0;
      wake_id  <= '0;
      cmpl_exc <= 1'b0;
      cmpl_id  <= '0;
    end else begin
      // abort takes effect first, wake-up follows after the instruction completes
      pend     <= abort_retry;
      pend_id  <= abort_retry ? own_id : '0;
      wake_exc <= pend;
      wake_id  <= pend_id;
      cmpl_exc <= fin_valid & fin_except;
      cmpl_id  <= (fin_valid & fin_except) ? fin_id : '0;
    end
  end
endmodule

// File: rtl/txn_conflict_unit.sv
module txn_conflict_unit #(
  parameter int PRIO_W      = 4,
  parameter int TXN_W       = 6,
  parameter int ID_W        = 8,
  parameter int STALL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_write,
  input  logic              own_is_write,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] own_prio,
  input  logic [TXN_W-1:0]  req_txn,
  input  logic [TXN_W-1:0]  own_txn,
  input  logic              same_thread,
  input  logic              own_paused,
  input  logic              own_retry,
  input  logic              own_done,
  input  logic [ID_W-1:0]   own_id,
  input  logic              fin_valid,
  input  logic              fin_except,
  input  logic [ID_W-1:0]   fin_id,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic              wait_exc,
  output logic [ID_W-1:0]   wait_owner_id,
  output logic              wake_exc,
  output logic [ID_W-1:0]   wake_id,
  output logic              cmpl_exc,
  output logic [ID_W-1:0]   cmpl_id
);
  import cr_pkg::*;

  logic hit, req_wins, live, owner_wins, abort_retry, timeout, wait_fire;
  cr_verdict_t verdict_nxt;

  cr_classify #(.PRIO_W(PRIO_W), .TXN_W(TXN_W)) u_cls (
    .req_is_write(req_is_write), .own_is_write(own_is_write),
    .req_prio(req_prio), .own_prio(own_prio),
    .req_txn(req_txn), .own_txn(own_txn),
    .same_thread(same_thread), .own_paused(own_paused), .own_retry(own_retry),
    .hit(hit), .req_wins(req_wins)
  );

  assign live        = req_valid & hit;
  assign owner_wins  = live & ~req_wins;
  assign abort_retry = live & req_wins & own_retry;

  cr_stall_timer #(.STALL_LIMIT(STALL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .owner_wins(owner_wins), .own_done(own_done),
    .timeout(timeout), .wait_fire(wait_fire)
  );

  cr_events #(.ID_W(ID_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .abort_retry(abort_retry), .own_id(own_id),
    .fin_valid(fin_valid), .fin_except(fin_except), .fin_id(fin_id),
    .wake_exc(wake_exc), .wake_id(wake_id), .cmpl_exc(cmpl_exc), .cmpl_id(cmpl_id)
  );

  always_comb begin
    if (!live)          verdict_nxt = CR_NONE;
    else if (req_wins)  verdict_nxt = CR_ABORT_OWNER;
    else if (wait_fire) verdict_nxt = CR_WAIT_EXC;
    else                verdict_nxt = CR_STALL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_code      <= 2'd0;
      wait_exc      <= 1'b0;
      wait_owner_id <= '0;
    end else begin
      res_valid     <= req_valid;
      res_code      <= verdict_nxt;
      wait_exc      <= wait_fire;
      wait_owner_id <= wait_fire ? own_id : '0;
    end
  end
endmodule

// File: rtl/txn_conflict_unit_checker.sv
module txn_conflict_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_is_write,
  input logic       own_is_write,
  input logic       same_thread,
  input logic       own_paused,
  input logic       own_retry,
  input logic       own_done,
  input logic       fin_valid,
  input logic       fin_except,
  input logic       res_valid,
  input logic [1:0] res_code,
  input logic       wait_exc,
  input logic       wake_exc,
  input logic       cmpl_exc,
  input logic       owner_wins,
  input logic       timeout
);
  a_r1_read_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_write && !own_is_write) |=> (res_valid && res_code == 2'd0));

  a_r3_paused_self_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && same_thread && own_paused) |=> (res_code == 2'd0));

  a_r5_retry_owner_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_is_write || own_is_write) && !(same_thread && own_paused) && own_retry)
      |=> (res_code == 2'd2));

  a_r6_wait_only_on_owner_win: assert property (@(posedge clk) disable iff (!rst_n)
    wait_exc |-> (res_valid && res_code == 2'd3));

  a_r6_stall_timeout_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !own_done) |=> wait_exc);

  a_r7_finishing_owner_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && own_done) |=> !wait_exc);

  a_r8_retry_abort_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_is_write || own_is_write) && !(same_thread && own_paused) && own_retry)
      |=> ##1 wake_exc);

  a_r9_completion_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && fin_except) |=> cmpl_exc);

  a_r9_no_spurious_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_valid && fin_except) |=> !cmpl_exc);

  a_r11_no_stall_without_win: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_wins |=> !(res_code == 2'd1) && !wait_exc);
endmodule

bind txn_conflict_unit txn_conflict_unit_checker u_chk (.*);

// File: tb/txn_conflict_unit_tb.sv
module txn_conflict_unit_tb;
  localparam int PW = 2, TW = 2, IW = 8, LIM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_is_write = 0, own_is_write = 0;
  logic [PW-1:0] req_prio = 0, own_prio = 0;
  logic [TW-1:0] req_txn = 0, own_txn = 0;
  logic same_thread = 0, own_paused = 0, own_retry = 0, own_done = 0;
  logic [IW-1:0] own_id = 0, fin_id = 0;
  logic fin_valid = 0, fin_except = 0;
  logic res_valid, wait_exc, wake_exc, cmpl_exc;
  logic [1:0] res_code;
  logic [IW-1:0] wait_owner_id, wake_id, cmpl_id;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txn_conflict_unit #(.PRIO_W(PW), .TXN_W(TW), .ID_W(IW), .STALL_LIMIT(LIM)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // requester wins when its (priority, inverted txn) key is strictly larger
  function automatic bit exp_req_wins(input int rp, input int op, input int rt, input int ot, input bit rty);
    int rk, ok;
    rk = rp * 16 + (3 - rt);
    ok = op * 16 + (3 - ot);
    return rty || (rk > ok);
  endfunction

  task automatic owner_win_setup();
    req_valid = 1; req_is_write = 1; own_is_write = 0;
    req_prio = 1; own_prio = 2; req_txn = 0; own_txn = 3;
    same_thread = 0; own_paused = 0; own_retry = 0; own_done = 0; own_id = 8'h5A;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: outputs held at zero in reset
    repeat (3) @(negedge clk);
    chk("R10 res_valid", res_valid, 0);
    chk("R10 res_code", res_code, 0);
    chk("R10 wait_exc", wait_exc, 0);
    chk("R10 wake_exc", wake_exc, 0);
    chk("R10 cmpl_exc", cmpl_exc, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R8: exhaustive single-cycle sweep
    for (int v = 0; v < 8192; v++) begin
      bit rw, ow, ps, rt, st, conf, win;
      int rp, op, rtx, otx, ev, ew;
      rw = v[0]; ow = v[1]; rp = v[3:2]; op = v[5:4]; rtx = v[7:6]; otx = v[9:8];
      ps = v[10]; rt = v[11]; st = v[12];
      req_valid = 1; req_is_write = rw; own_is_write = ow;
      req_prio = PW'(rp); own_prio = PW'(op); req_txn = TW'(rtx); own_txn = TW'(otx);
      own_paused = ps; own_retry = rt; same_thread = st; own_id = IW'(v * 7 + 1);
      conf = (rw || ow) && !(st && ps);
      win = exp_req_wins(rp, op, rtx, otx, rt);
      if (!conf) ev = 0; else if (win) ev = 2; else ev = 1;
      ew = conf && win && rt;
      @(negedge clk);
      if (!rw && !ow)      chk("R1 read/read verdict", res_code, ev);
      else if (st && ps)   chk("R3 paused self verdict", res_code, ev);
      else if (rt)         chk("R5 retry owner verdict", res_code, ev);
      else if (win)        chk("R2 abort owner verdict", res_code, ev);
      else                 chk("R4 owner wins verdict", res_code, ev);
      chk("R6 no early wait", wait_exc, 0);
      req_valid = 0;
      @(negedge clk);
      chk("R8 wake pulse", wake_exc, ew);
      if (ew) chk("R8 wake id", wake_id, (v * 7 + 1) % 256);
    end
    @(negedge clk);

    // R6: held owner win, wait on cycle LIM, restart after
    owner_win_setup();
    for (int k = 1; k <= LIM + 1; k++) begin
      @(negedge clk);
      chk("R6 stall run verdict", res_code, (k == LIM) ? 3 : 1);
      chk("R6 wait pulse", wait_exc, k == LIM);
      if (k == LIM) chk("R6 wait owner id", wait_owner_id, 8'h5A);
    end
    req_valid = 0; @(negedge clk); @(negedge clk);

    // R7: owner finishing at the limit
    owner_win_setup(); own_done = 1;
    for (int k = 1; k <= LIM * 2; k++) begin
      @(negedge clk);
      chk("R7 finishing owner verdict", res_code, 1);
      chk("R7 no wait pulse", wait_exc, 0);
    end
    own_done = 0;
    for (int k = 1; k <= LIM; k++) begin
      @(negedge clk);
      chk("R7 count restarted", wait_exc, k == LIM);
    end
    req_valid = 0; @(negedge clk); @(negedge clk);

    // R11: interruption clears the count
    owner_win_setup();
    for (int k = 1; k < LIM; k++) @(negedge clk);
    req_is_write = 0; @(negedge clk);
    chk("R11 interrupt verdict", res_code, 0);
    req_is_write = 1;
    for (int k = 1; k <= LIM; k++) begin
      @(negedge clk);
      chk("R11 wait after restart", wait_exc, k == LIM);
    end
    req_valid = 0; @(negedge clk); @(negedge clk);

    // R9: completion exception
    fin_valid = 1; fin_except = 1; fin_id = 8'hC3;
    @(negedge clk);
    chk("R9 completion pulse", cmpl_exc, 1);
    chk("R9 completion id", cmpl_id, 8'hC3);
    fin_except = 0; fin_id = 8'h11;
    @(negedge clk);
    chk("R9 no pulse without flag", cmpl_exc, 0);
    fin_valid = 0; fin_except = 1;
    @(negedge clk);
    chk("R9 no pulse without event", cmpl_exc, 0);
    fin_except = 0;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule